// File: doc/BRIEF.md
# Mask-Constrained Counter Slot Allocator

This block hands out physical counter slots in a performance-monitoring unit with ten slots. Each request names either an event class, which a decoder turns into a 10-bit eligibility mask, or a raw mask given directly. The allocator grants the lowest-numbered slot that is both eligible and free. It marks that slot occupied and returns its index, or it returns a failure indication. Slots can be returned one at a time, or all of them can be emptied at once.

Requests are served strictly in the order they arrive, through a valid/ready handshake. The allocator never moves an earlier grant and never searches for a better assignment. A narrow request can therefore fail only because a wide request placed before it took the single slot it could use. Software that wants every request to succeed must present the narrow classes first.

Top module: `pmu_slot_allocator`

## Requirements
- R1: After reset the occupancy vector is all zeros, `gnt_valid` is 0 and `rel_warn` is 0.
- R2: Class codes decode as follows: 0 allows only slot 0; 1 allows only slot 1; 2 allows only slot 6; 3 allows slots 5, 6 and 7; 4 allows slots 2 to 9. Codes 5, 6 and 7 allow no slot, so such a request always fails.
- R3: When `req_raw` is 1, the eligibility mask is `req_mask`, where bit i stands for slot i. `req_class` is then ignored.
- R4: A request is granted the lowest-indexed slot that is set in its eligibility mask and is not occupied. Occupied slots are skipped.
- R5: A request accepted at a clock edge produces `gnt_valid` = 1 for exactly the next cycle. On success `gnt_ok` = 1, `gnt_slot` holds the slot index and that slot's occupancy bit is set.
- R6: When no eligible slot is free, `gnt_ok` = 0, `gnt_slot` = 0 and the occupancy vector is left unchanged.
- R7: There is no backtracking. With slots 2 to 7 taken by class-4 requests, a class-2 request and a class-3 request both fail.
- R8: A release (`rel_valid` = 1) of an occupied slot `rel_slot` clears that occupancy bit at the next edge.
- R9: A release of a free slot, or of an index of 10 or more, leaves occupancy unchanged and sets the sticky `rel_warn` flag.
- R10: `clr_all` empties every slot and clears `rel_warn` at the next edge. While `clr_all` is 1, `req_ready` is 0 and no request is accepted.
- R11: When a release and an accepted request fall in the same cycle, the request sees the occupancy from before the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Allocation request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_raw | input | 1 | 1: use req_mask, 0: decode req_class |
| req_class | input | 3 | Event class code |
| req_mask | input | 10 | Raw eligibility mask |
| gnt_valid | output | 1 | Grant result valid (one cycle) |
| gnt_ok | output | 1 | 1: slot granted, 0: allocation failed |
| gnt_slot | output | 4 | Granted slot index |
| rel_valid | input | 1 | Release one slot |
| rel_slot | input | 4 | Slot index to release |
| clr_all | input | 1 | Empty all slots |
| occ | output | 10 | Current occupancy vector |
| rel_warn | output | 1 | Sticky flag: a release hit a free or invalid slot |

## Verification
The assertions check several rules on every cycle. The picked slot is one-hot and no eligible free slot lies below it. Each accept yields exactly one grant pulse, and a successful grant leaves its slot occupied. A failed grant leaves occupancy untouched. Clear empties the vector and blocks acceptance, and the warning flag stays set until a clear.

Only the bench's scenarios can show the class decode and the order dependence. That means the general requests that block the narrow and mid classes, and the reordered sequence in which those same classes succeed. The same holds for the raw-mask override and for the meaning of a release that coincides with a request.

// File: rtl/pmu_slot_pkg.sv
package pmu_slot_pkg;
  localparam int NSLOT  = 10;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int CLS_W  = 3;

  typedef enum logic [CLS_W-1:0] {
    EV_CYCLES  = 3'd0,
    EV_INSTR   = 3'd1,
    EV_NARROW  = 3'd2,
    EV_MID     = 3'd3,
    EV_GENERAL = 3'd4
  } ev_class_e;

  // eligibility mask of an event class; unknown codes allow nothing
  function automatic logic [NSLOT-1:0] class_mask(input logic [CLS_W-1:0] code);
    logic [NSLOT-1:0] m;
    m = '0;
    case (code)
      EV_CYCLES:  m[0] = 1'b1;
      EV_INSTR:   m[1] = 1'b1;
      EV_NARROW:  m[6] = 1'b1;
      EV_MID:     m[7:5] = 3'b111;
      EV_GENERAL: m[9:2] = 8'hFF;
      default:    m = '0;
    endcase
    return m;
  endfunction

  // binary index of a one-hot vector (zero when empty)
  function automatic logic [SLOT_W-1:0] onehot_index(input logic [NSLOT-1:0] oh);
    logic [SLOT_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < NSLOT; i++)
      if (oh[i]) idx = idx | SLOT_W'(i);
    return idx;
  endfunction
endpackage

// File: rtl/pmu_ev_mask_decode.sv
module pmu_ev_mask_decode
  import pmu_slot_pkg::*;
(
  input  logic             raw_sel,
  input  logic [CLS_W-1:0] cls,
  input  logic [NSLOT-1:0] raw_mask,
  output logic [NSLOT-1:0] elig
);
  assign elig = raw_sel ? raw_mask : class_mask(cls);
endmodule

// File: rtl/pmu_lowest_pick.sv
module pmu_lowest_pick
  import pmu_slot_pkg::*;
(
  input  logic [NSLOT-1:0]  cand,
  output logic [NSLOT-1:0]  pick_onehot,
  output logic              pick_hit,
  output logic [SLOT_W-1:0] pick_idx
);
  // below[i]: some candidate exists at an index lower than i
  logic [NSLOT-1:0] below;

  for (genvar i = 0; i < NSLOT; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign below[i] = 1'b0;
    end else begin : g_rest
      assign below[i] = below[i-1] | cand[i-1];
    end
    assign pick_onehot[i] = cand[i] & ~below[i];
  end

  assign pick_hit = |pick_onehot;
  assign pick_idx = onehot_index(pick_onehot);
endmodule

// File: rtl/pmu_slot_occupancy.sv
module pmu_slot_occupancy
  import pmu_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  set_onehot,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  input  logic              clr_all,
  output logic [NSLOT-1:0]  occ_q,
  output logic              warn_q,
  output logic              rel_ignored
);
  logic [NSLOT-1:0] rel_onehot;
  logic             rel_hit;

  always_comb begin
    rel_onehot = '0;
    if (rel_valid && (rel_slot < SLOT_W'(NSLOT)))
      rel_onehot = NSLOT'(1) << rel_slot;
  end

  assign rel_hit     = |(rel_onehot & occ_q);
  assign rel_ignored = rel_valid & ~rel_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q  <= '0;
      warn_q <= 1'b0;
    end else if (clr_all) begin
      occ_q  <= '0;
      warn_q <= 1'b0;
    end else begin
      occ_q  <= (occ_q & ~(rel_hit ? rel_onehot : '0)) | set_onehot;
      warn_q <= warn_q | rel_ignored;
    end
  end
endmodule

// File: rtl/pmu_slot_allocator.sv
module pmu_slot_allocator
  import pmu_slot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_raw,
  input  logic [CLS_W-1:0]  req_class,
  input  logic [NSLOT-1:0]  req_mask,
  output logic              gnt_valid,
  output logic              gnt_ok,
  output logic [SLOT_W-1:0] gnt_slot,
  input  logic              rel_valid,
  input  logic [SLOT_W-1:0] rel_slot,
  input  logic              clr_all,
  output logic [NSLOT-1:0]  occ,
  output logic              rel_warn
);
  // named internal events, observed by the bound checker
  logic              accept;
  logic [NSLOT-1:0]  elig;
  logic [NSLOT-1:0]  cand;
  logic [NSLOT-1:0]  pick_onehot;
  logic              pick_hit;
  logic [SLOT_W-1:0] pick_idx;
  logic [NSLOT-1:0]  set_onehot;
  logic              rel_ignored;

  logic              gnt_valid_q;
  logic              gnt_ok_q;
  logic [SLOT_W-1:0] gnt_slot_q;

  assign req_ready = ~clr_all;
  assign accept    = req_valid & req_ready;

  pmu_ev_mask_decode u_decode (
    .raw_sel (req_raw),
    .cls     (req_class),
    .raw_mask(req_mask),
    .elig    (elig)
  );

  assign cand = elig & ~occ;

  pmu_lowest_pick u_pick (
    .cand       (cand),
    .pick_onehot(pick_onehot),
    .pick_hit   (pick_hit),
    .pick_idx   (pick_idx)
  );

  assign set_onehot = accept ? pick_onehot : '0;

  pmu_slot_occupancy u_occ (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_onehot (set_onehot),
    .rel_valid  (rel_valid),
    .rel_slot   (rel_slot),
    .clr_all    (clr_all),
    .occ_q      (occ),
    .warn_q     (rel_warn),
    .rel_ignored(rel_ignored)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid_q <= 1'b0;
      gnt_ok_q    <= 1'b0;
      gnt_slot_q  <= '0;
    end else begin
      gnt_valid_q <= accept;
      if (accept) begin
        gnt_ok_q   <= pick_hit;
        gnt_slot_q <= pick_hit ? pick_idx : '0;
      end
    end
  end

  assign gnt_valid = gnt_valid_q;
  assign gnt_ok    = gnt_ok_q;
  assign gnt_slot  = gnt_slot_q;
endmodule

// File: rtl/pmu_slot_alloc_chk.sv
module pmu_slot_alloc_chk
  import pmu_slot_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              clr_all,
  input logic              rel_valid,
  input logic              rel_ignored,
  input logic [NSLOT-1:0]  cand,
  input logic [NSLOT-1:0]  pick_onehot,
  input logic [NSLOT-1:0]  occ,
  input logic              rel_warn,
  input logic              gnt_valid,
  input logic              gnt_ok,
  input logic [SLOT_W-1:0] gnt_slot
);
  // R4: at most one slot picked, and no candidate below it
  assert_pick_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_onehot));
  assert_pick_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((pick_onehot - NSLOT'(1)) & cand) == '0));

  // R5: one grant pulse per accept
  assert_grant_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> gnt_valid);
  assert_grant_only_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !gnt_valid);
  assert_grant_marks_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_ok) |-> ((gnt_slot < SLOT_W'(NSLOT)) && occ[gnt_slot]));

  // R6: a failed request leaves occupancy as it was
  assert_fail_keeps_occ_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !rel_valid |=> (gnt_ok || (occ == $past(occ))));

  // R10: clear empties everything and blocks acceptance
  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (occ == '0 && !rel_warn));
  assert_clear_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |-> !accept);

  // R9: warning is raised by an ignored release and held until clear
  assert_warn_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ignored && !clr_all) |=> rel_warn);
  assert_warn_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_warn && !clr_all) |=> rel_warn);
endmodule

bind pmu_slot_allocator pmu_slot_alloc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .clr_all    (clr_all),
  .rel_valid  (rel_valid),
  .rel_ignored(rel_ignored),
  .cand       (cand),
  .pick_onehot(pick_onehot),
  .occ        (occ),
  .rel_warn   (rel_warn),
  .gnt_valid  (gnt_valid),
  .gnt_ok     (gnt_ok),
  .gnt_slot   (gnt_slot)
);

// File: tb/tb_pmu_slot_allocator.sv
`timescale 1ns/1ps
module tb_pmu_slot_allocator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_raw = 1'b0;
  logic [2:0] req_class = 3'd0;
  logic [9:0] req_mask = 10'd0;
  logic       gnt_valid;
  logic       gnt_ok;
  logic [3:0] gnt_slot;
  logic       rel_valid = 1'b0;
  logic [3:0] rel_slot = 4'd0;
  logic       clr_all = 1'b0;
  logic [9:0] occ;
  logic       rel_warn;

  int n_chk = 0;
  int n_bad = 0;
  logic [9:0] exp_occ = 10'd0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  pmu_slot_allocator dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_raw(req_raw), .req_class(req_class), .req_mask(req_mask),
    .gnt_valid(gnt_valid), .gnt_ok(gnt_ok), .gnt_slot(gnt_slot),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .clr_all(clr_all),
    .occ(occ), .rel_warn(rel_warn)
  );

  // vector: {clear_op, raw, class[2:0], mask[9:0], exp_ok, exp_slot[3:0]}
  localparam int NV = 27;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd2},   // R2 R4 general lowest
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd3},
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd4},
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd5},
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd6},
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd7},
    {1'b0, 1'b0, 3'd2, 10'h000, 1'b0, 4'd0},   // R7 narrow blocked
    {1'b0, 1'b0, 3'd3, 10'h000, 1'b0, 4'd0},   // R7 mid blocked
    {1'b0, 1'b0, 3'd0, 10'h000, 1'b1, 4'd0},   // R2 cycles
    {1'b0, 1'b0, 3'd0, 10'h000, 1'b0, 4'd0},   // R6 slot 0 taken
    {1'b0, 1'b0, 3'd1, 10'h000, 1'b1, 4'd1},   // R2 instructions
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd8},
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd9},
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b0, 4'd0},   // R6 all general taken
    {1'b0, 1'b0, 3'd6, 10'h000, 1'b0, 4'd0},   // R2 undefined code
    {1'b0, 1'b1, 3'd4, 10'h000, 1'b0, 4'd0},   // R3 raw empty mask
    {1'b1, 1'b0, 3'd0, 10'h000, 1'b0, 4'd0},   // clear
    {1'b0, 1'b0, 3'd2, 10'h000, 1'b1, 4'd6},   // R7 narrow first succeeds
    {1'b0, 1'b0, 3'd3, 10'h000, 1'b1, 4'd5},   // R4 skips nothing
    {1'b0, 1'b0, 3'd3, 10'h000, 1'b1, 4'd7},   // R4 skips 5,6
    {1'b0, 1'b0, 3'd3, 10'h000, 1'b0, 4'd0},   // R6 mid full
    {1'b0, 1'b0, 3'd4, 10'h000, 1'b1, 4'd2},
    {1'b0, 1'b1, 3'd0, 10'h210, 1'b1, 4'd4},   // R3 raw bits 4,9
    {1'b0, 1'b1, 3'd0, 10'h210, 1'b1, 4'd9},
    {1'b0, 1'b1, 3'd0, 10'h210, 1'b0, 4'd0},
    {1'b0, 1'b1, 3'd2, 10'h003, 1'b1, 4'd0},   // R3 class ignored
    {1'b0, 1'b1, 3'd0, 10'h3FF, 1'b1, 4'd1}    // R3 class 0 would fail
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // drive one request at a negedge, sample the registered result at the next
  task automatic do_req(input logic raw, input logic [2:0] cls, input logic [9:0] msk);
    req_valid = 1'b1; req_raw = raw; req_class = cls; req_mask = msk;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_rel(input logic [3:0] s);
    rel_valid = 1'b1; rel_slot = s;
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 occupancy after reset", 32'(occ), 32'h0);
    check("R1 grant idle after reset", 32'(gnt_valid), 32'h0);
    check("R1 warning after reset", 32'(rel_warn), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [19:0] e;
      e = VEC[v];
      if (e[19]) begin
        clr_all = 1'b1;
        @(negedge clk);
        clr_all = 1'b0;
        exp_occ = '0;
        check($sformatf("R10 clear vector %0d", v), 32'(occ), 32'h0);
      end else begin
        do_req(e[18], e[17:15], e[14:5]);
        if (e[4]) exp_occ[e[3:0]] = 1'b1;
        check($sformatf("R4 R5 R6 vector %0d {valid,ok,slot,occ}", v),
              {15'd0, gnt_valid, gnt_ok, gnt_slot, occ},
              {15'd0, 1'b1, e[4], e[3:0], exp_occ});
      end
    end

    // R5: grant is a single-cycle pulse
    @(negedge clk);
    check("R5 grant drops after one cycle", 32'(gnt_valid), 32'h0);

    // R8: release an occupied slot
    do_rel(4'd6);
    exp_occ[6] = 1'b0;
    check("R8 release clears bit 6", 32'(occ), 32'(exp_occ));
    check("R8 valid release no warning", 32'(rel_warn), 32'h0);

    // R9: release of a free slot and of an invalid index
    do_rel(4'd6);
    check("R9 free release leaves occupancy", 32'(occ), 32'(exp_occ));
    check("R9 free release warns", 32'(rel_warn), 32'h1);
    do_rel(4'd12);
    check("R9 invalid index leaves occupancy", 32'(occ), 32'(exp_occ));
    check("R9 warning sticky", 32'(rel_warn), 32'h1);

    // R11: release of slot 0 with a cycles request in the same cycle
    rel_valid = 1'b1; rel_slot = 4'd0;
    do_req(1'b0, 3'd0, 10'h000);
    rel_valid = 1'b0;
    exp_occ[0] = 1'b0;
    check("R11 request sees pre-release occupancy {ok,slot}",
          {27'd0, gnt_ok, gnt_slot}, {27'd0, 1'b0, 4'd0});
    check("R11 release still applied", 32'(occ), 32'(exp_occ));

    // R10: clear with a request pending
    clr_all = 1'b1; req_valid = 1'b1; req_raw = 1'b0; req_class = 3'd4;
    #1;
    check("R10 ready low during clear", 32'(req_ready), 32'h0);
    @(negedge clk);
    clr_all = 1'b0; req_valid = 1'b0;
    check("R10 request not accepted during clear", 32'(gnt_valid), 32'h0);
    check("R10 clear empties occupancy", 32'(occ), 32'h0);
    check("R10 clear drops warning", 32'(rel_warn), 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule